// File: doc/BRIEF.md
# Power-Management Sticky Status Register

This block is an 8-bit power-management status and configuration register that lives in the always-on resume well. A simple register bus reaches it at one fixed address. When the bus address matches, the register drives its contents onto the read data; for any other address it drives zero. A write at the matching address updates the scratch flag and clears the status bits selected by ones in the write data.

The register holds four kinds of state. The first is a scratch flag that firmware sets before memory training and clears after it, so the flag reveals an interrupted training run. The second is a read-only indicator that memory stayed in self-refresh. The third is a pair of sticky flags, one for a reset-button press and one for a processor thermal trip. The fourth is a flag raised by a built-in timer when the deep-sleep strobe was held for less than a programmed minimum width.

The bits differ in what clears them. The resume-well reset clears every bit. The warm reset class, which covers the reset button, power-good loss, a hard bus reset and a watchdog timeout, clears only the button flag and the thermal flag.

Top module: `pm_sts_reg`

## Requirements
- R1: Reset value and decode. After resume-well reset (`rst`) the register reads 0x00. A read with `bus_addr` equal to REG_ADDR (default 0xA2) returns the register. Any other address returns 0x00. Bits 6, 1 and 0 always read 0.
- R2: Bit 7 is a scratch flag. A write at REG_ADDR loads `bus_wdata[7]` into it. `rst` clears it. `warm_rst` leaves it unchanged.
- R3: Bit 5 is read-only. It loads `mem_sr_in` in a cycle where `sr_capture` is high. Bus writes never change it, and `rst` clears it.
- R4: Bit 4 becomes 1 in a cycle where `sys_btn` and `main_pwr_ok` are both high. Writing 1 to bit 4 clears it, and so do `warm_rst` and `rst`. If a set and a clear happen in the same cycle, the set wins.
- R5: While `main_pwr_ok` is low, `sys_btn` has no effect on bit 4.
- R6: Bit 3 becomes 1 on a low-to-high change of `thermtrip`, but only while `plat_rst_act` is low and `in_s0s1` is high. Writing 1 to bit 3 clears it, and so do `warm_rst` and `rst`. A `thermtrip` level that stays high does not set the bit again.
- R7: Bit 2 is set when `slp_strobe` is seen low while the width timer runs and the timer has counted fewer `tb_tick` pulses than the limit selected by `min_width_code`. Code 00 selects LIM0, 01 selects LIM1, 10 selects LIM2 and 11 selects LIM3. The timer restarts from zero when `slp_strobe` rises and when `rst` is released, and it stops once the limit is reached. Writing 1 to bit 2 clears it, and so does `rst`. `warm_rst` does not clear it.
- R8: A write of 0 to a bit position among 4, 3 and 2 leaves that bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Resume-well clock |
| rst | input | 1 | Resume-well reset, synchronous, active high |
| warm_rst | input | 1 | Warm (core-well) reset class pulse |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register |
| sys_btn | input | 1 | Reset-button input, active high |
| main_pwr_ok | input | 1 | Main well powered; while low, the button input is masked |
| thermtrip | input | 1 | Processor thermal-trip input, active high |
| plat_rst_act | input | 1 | Platform reset currently asserted |
| in_s0s1 | input | 1 | System in a working or light-sleep state |
| sr_capture | input | 1 | Strobe that loads the self-refresh indicator |
| mem_sr_in | input | 1 | Self-refresh indication from the sequencer |
| slp_strobe | input | 1 | Deep-sleep strobe, high when asserted |
| tb_tick | input | 1 | Slow timebase pulse that drives the width timer |
| min_width_code | input | 2 | Minimum-width selection from the neighbouring register |

## Verification
The hardest case to reach is the width check that starts at power-up, because the timer starts from the release of the resume-well reset and not from any strobe edge. The stimulus asserts reset a second time with the strobe already low, then releases it. The flag must appear on the first edge after release. The edges of the width window are covered by holding the strobe for exactly one tick less than the limit and then for exactly the limit.

// File: rtl/pm_sts_pkg.sv
package pm_sts_pkg;

    localparam int unsigned REG_W = 8;

    // Field layout of the status register (bit positions are architectural)
    typedef struct packed {
        logic       scratch;    // 7
        logic       rsvd6;      // 6
        logic       mem_sr;     // 5
        logic       rst_btn;    // 4
        logic       therm;      // 3
        logic       slp_short;  // 2
        logic [1:0] rsvd;       // 1:0
    } pm_sts_t;

    // Qualified hardware events feeding the sticky bits
    typedef struct packed {
        logic btn;
        logic therm;
    } pm_evt_t;

    // Sticky bit next state: a set beats any clear
    function automatic logic sticky_next(input logic cur, input logic set,
                                         input logic hw_clr, input logic sw_clr);
        if (set)
            return 1'b1;
        else if (hw_clr || sw_clr)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/pm_sts_event_cond.sv
module pm_sts_event_cond
    import pm_sts_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sys_btn,
    input  logic    main_pwr_ok,
    input  logic    thermtrip,
    input  logic    plat_rst_act,
    input  logic    in_s0s1,
    output pm_evt_t evt
);

    logic therm_q;

    always_ff @(posedge clk) begin
        if (rst)
            therm_q <= 1'b0;
        else
            therm_q <= thermtrip;
    end

    always_comb begin
        // isolation mask: button is meaningless while the main well is off
        evt.btn   = sys_btn & main_pwr_ok;
        evt.therm = thermtrip & ~therm_q & ~plat_rst_act & in_s0s1;
    end

endmodule

// File: rtl/pm_slp_width_timer.sv
module pm_slp_width_timer #(
    parameter int unsigned LIM0 = 2,
    parameter int unsigned LIM1 = 4,
    parameter int unsigned LIM2 = 8,
    parameter int unsigned LIM3 = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slp_strobe,
    input  logic       tb_tick,
    input  logic [1:0] min_width_code,
    output logic       viol
);

    localparam int unsigned LIM_MAX01 = (LIM0 > LIM1) ? LIM0 : LIM1;
    localparam int unsigned LIM_MAX23 = (LIM2 > LIM3) ? LIM2 : LIM3;
    localparam int unsigned LIM_MAX   = (LIM_MAX01 > LIM_MAX23) ? LIM_MAX01 : LIM_MAX23;
    localparam int unsigned CNT_W     = $clog2(LIM_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             timing_q;
    logic             strobe_q;
    logic             strobe_rise;
    logic             reached;

    always_comb begin
        unique case (min_width_code)
            2'd0:    lim = CNT_W'(LIM0);
            2'd1:    lim = CNT_W'(LIM1);
            2'd2:    lim = CNT_W'(LIM2);
            default: lim = CNT_W'(LIM3);
        endcase
    end

    assign strobe_rise = slp_strobe & ~strobe_q;
    assign reached     = (cnt_q >= lim);
    assign viol        = timing_q & ~slp_strobe & ~reached & ~rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            timing_q <= 1'b1;          // power-up start at reset release
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= slp_strobe;
            if (strobe_rise) begin
                timing_q <= 1'b1;
                cnt_q    <= '0;
            end else if (timing_q) begin
                if (!slp_strobe || reached)
                    timing_q <= 1'b0;
                else if (tb_tick)
                    cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pm_sts_bits.sv
module pm_sts_bits
    import pm_sts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       warm_rst,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    input  pm_evt_t    evt,
    input  logic       sr_capture,
    input  logic       mem_sr_in,
    input  logic       slp_viol,
    output pm_sts_t    sts
);

    pm_sts_t wr_f;
    logic    unused_wr;

    assign wr_f      = pm_sts_t'(wdata);
    assign unused_wr = ^{wr_f.rsvd6, wr_f.mem_sr, wr_f.rsvd};

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
        end else begin
            if (wr_hit)
                sts.scratch <= wr_f.scratch;
            if (sr_capture)
                sts.mem_sr <= mem_sr_in;
            sts.rst_btn   <= sticky_next(sts.rst_btn, evt.btn, warm_rst,
                                         wr_hit & wr_f.rst_btn);
            sts.therm     <= sticky_next(sts.therm, evt.therm, warm_rst,
                                         wr_hit & wr_f.therm);
            sts.slp_short <= sticky_next(sts.slp_short, slp_viol, 1'b0,
                                         wr_hit & wr_f.slp_short);
            sts.rsvd6     <= 1'b0;
            sts.rsvd      <= '0;
        end
    end

endmodule

// File: rtl/pm_sts_reg.sv
module pm_sts_reg
    import pm_sts_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'hA2,
    parameter int unsigned LIM0     = 2,
    parameter int unsigned LIM1     = 4,
    parameter int unsigned LIM2     = 8,
    parameter int unsigned LIM3     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    input  logic              sys_btn,
    input  logic              main_pwr_ok,
    input  logic              thermtrip,
    input  logic              plat_rst_act,
    input  logic              in_s0s1,
    input  logic              sr_capture,
    input  logic              mem_sr_in,
    input  logic              slp_strobe,
    input  logic              tb_tick,
    input  logic [1:0]        min_width_code
);

    localparam logic [ADDR_W-1:0] ADDR_MATCH = ADDR_W'(REG_ADDR);

    logic    addr_hit;
    logic    wr_hit;
    logic    slp_viol;
    pm_evt_t evt;
    pm_sts_t sts_q;

    assign addr_hit = (bus_addr == ADDR_MATCH);
    assign wr_hit   = bus_wr & addr_hit;
    assign rd_data  = addr_hit ? 8'(sts_q) : 8'h00;

    pm_sts_event_cond u_evt (
        .clk          (clk),
        .rst          (rst),
        .sys_btn      (sys_btn),
        .main_pwr_ok  (main_pwr_ok),
        .thermtrip    (thermtrip),
        .plat_rst_act (plat_rst_act),
        .in_s0s1      (in_s0s1),
        .evt          (evt)
    );

    pm_slp_width_timer #(
        .LIM0 (LIM0),
        .LIM1 (LIM1),
        .LIM2 (LIM2),
        .LIM3 (LIM3)
    ) u_tmr (
        .clk            (clk),
        .rst            (rst),
        .slp_strobe     (slp_strobe),
        .tb_tick        (tb_tick),
        .min_width_code (min_width_code),
        .viol           (slp_viol)
    );

    pm_sts_bits u_bits (
        .clk        (clk),
        .rst        (rst),
        .warm_rst   (warm_rst),
        .wr_hit     (wr_hit),
        .wdata      (bus_wdata),
        .evt        (evt),
        .sr_capture (sr_capture),
        .mem_sr_in  (mem_sr_in),
        .slp_viol   (slp_viol),
        .sts        (sts_q)
    );

endmodule

// File: rtl/pm_sts_reg_chk.sv
module pm_sts_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       warm_rst,
    input logic       wr_hit,
    input logic [7:0] wdata,
    input logic       sys_btn,
    input logic       main_pwr_ok,
    input logic       thermtrip,
    input logic       plat_rst_act,
    input logic       in_s0s1,
    input logic       slp_strobe,
    input logic [7:0] sts
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (sts == 8'h00)); // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sts[6] == 1'b0) && (sts[1:0] == 2'b00)); // R1

    AST_SCRATCH_WARM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (warm_rst && !wr_hit) |=> $stable(sts[7])); // R2

    AST_BTN_WARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (warm_rst && !(sys_btn && main_pwr_ok)) |=> !sts[4]); // R4

    AST_BTN_MASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(sts[4]) |-> $past(sys_btn && main_pwr_ok)); // R5

    AST_THERM_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(sts[3]) |-> $past(thermtrip && !plat_rst_act && in_s0s1)); // R6

    AST_WIDTH_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(sts[2]) |-> $past(!slp_strobe)); // R7

    AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !wdata[2] && sts[2]) |=> sts[2]); // R8

endmodule

bind pm_sts_reg pm_sts_reg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .warm_rst     (warm_rst),
    .wr_hit       (wr_hit),
    .wdata        (bus_wdata),
    .sys_btn      (sys_btn),
    .main_pwr_ok  (main_pwr_ok),
    .thermtrip    (thermtrip),
    .plat_rst_act (plat_rst_act),
    .in_s0s1      (in_s0s1),
    .slp_strobe   (slp_strobe),
    .sts          (sts_q)
);

// File: tb/pm_sts_reg_bench.sv
`timescale 1ns/1ps
module pm_sts_reg_bench;

    localparam real        HALF = 2.5;  // 200 MHz
    localparam logic [7:0] OFF  = 8'hA2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       warm_rst = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = OFF;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       sys_btn = 1'b0;
    logic       main_pwr_ok = 1'b0;
    logic       thermtrip = 1'b0;
    logic       plat_rst_act = 1'b1;
    logic       in_s0s1 = 1'b1;
    logic       sr_capture = 1'b0;
    logic       mem_sr_in = 1'b0;
    logic       slp_strobe = 1'b1;
    logic       tb_tick = 1'b0;
    logic [1:0] min_width_code = 2'd0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       chk_ev;

    always #(HALF) clk = ~clk;

    pm_sts_reg u_pm_sts_reg (
        .clk(clk), .rst(rst), .warm_rst(warm_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .sys_btn(sys_btn), .main_pwr_ok(main_pwr_ok), .thermtrip(thermtrip),
        .plat_rst_act(plat_rst_act), .in_s0s1(in_s0s1), .sr_capture(sr_capture),
        .mem_sr_in(mem_sr_in), .slp_strobe(slp_strobe), .tb_tick(tb_tick),
        .min_width_code(min_width_code)
    );

    // monitor: pops expected items and compares with the read port
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: rd_data=%02h expected=%02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        #0.1;
        -> chk_ev;
        #0.1;
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr = 1'b1;
        bus_wdata = d;
        cyc(1);
        bus_wr = 1'b0;
        bus_wdata = 8'h00;
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            tb_tick = 1'b1;
            cyc(1);
            tb_tick = 1'b0;
            cyc(1);
        end
    endtask

    task automatic warm_pulse();
        warm_rst = 1'b1;
        cyc(1);
        warm_rst = 1'b0;
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        expect_rd(8'h00, "R1 reset value");

        // R7: limit met with code 00, then release -> no flag
        tick(2);
        slp_strobe = 1'b0; cyc(1);
        expect_rd(8'h00, "R7 width met code00");
        // R7: code 01, one tick short
        min_width_code = 2'd1;
        slp_strobe = 1'b1; cyc(1);
        tick(3);
        slp_strobe = 1'b0; cyc(1);
        expect_rd(8'h04, "R7 short by one code01");
        wr(8'h00);
        expect_rd(8'h04, "R8 write zero keeps bit2");
        wr(8'h04);
        expect_rd(8'h00, "R7 w1c bit2");
        // R7: code 01, exactly the limit
        slp_strobe = 1'b1; cyc(1);
        tick(4);
        slp_strobe = 1'b0; cyc(1);
        expect_rd(8'h00, "R7 exact limit code01");
        // R7: code 11, short
        min_width_code = 2'd3;
        slp_strobe = 1'b1; cyc(1);
        tick(15);
        slp_strobe = 1'b0; cyc(1);
        expect_rd(8'h04, "R7 short code11");
        warm_pulse();
        expect_rd(8'h04, "R7 warm reset keeps bit2");
        wr(8'h04);
        expect_rd(8'h00, "R7 clear");

        // R2 scratch
        wr(8'h80);
        expect_rd(8'h80, "R2 scratch set");
        bus_addr = 8'hA4;
        #0.1;
        expect_rd(8'h00, "R1 other address");
        bus_addr = OFF;
        warm_pulse();
        expect_rd(8'h80, "R2 scratch survives warm");

        // R3 self-refresh indicator
        mem_sr_in = 1'b1; sr_capture = 1'b1; cyc(1);
        sr_capture = 1'b0; mem_sr_in = 1'b0;
        expect_rd(8'hA0, "R3 capture");
        wr(8'h80);
        expect_rd(8'hA0, "R3 write ignored");
        wr(8'hFF);
        expect_rd(8'hA0, "R1 R3 all-ones write");

        // R5 / R4 button
        main_pwr_ok = 1'b0; sys_btn = 1'b1; cyc(1); sys_btn = 1'b0;
        expect_rd(8'hA0, "R5 masked button");
        main_pwr_ok = 1'b1; sys_btn = 1'b1; cyc(1); sys_btn = 1'b0;
        expect_rd(8'hB0, "R4 button set");
        wr(8'hA0);
        expect_rd(8'hB0, "R8 write zero keeps bit4");
        wr(8'h90);
        expect_rd(8'hA0, "R4 w1c bit4");
        sys_btn = 1'b1; cyc(1); sys_btn = 1'b0;
        warm_pulse();
        expect_rd(8'hA0, "R4 warm clears bit4");
        sys_btn = 1'b1; warm_rst = 1'b1; cyc(1);
        sys_btn = 1'b0; warm_rst = 1'b0;
        expect_rd(8'hB0, "R4 set wins over warm");
        wr(8'h90);
        expect_rd(8'hA0, "R4 clear again");

        // R6 thermal trip
        plat_rst_act = 1'b1; thermtrip = 1'b1; cyc(1); thermtrip = 1'b0; cyc(1);
        expect_rd(8'hA0, "R6 blocked by platform reset");
        plat_rst_act = 1'b0; in_s0s1 = 1'b0;
        thermtrip = 1'b1; cyc(1); thermtrip = 1'b0; cyc(1);
        expect_rd(8'hA0, "R6 blocked outside S0/S1");
        in_s0s1 = 1'b1;
        thermtrip = 1'b1; cyc(1);
        expect_rd(8'hA8, "R6 trip set");
        wr(8'hA8);
        cyc(2);
        expect_rd(8'hA0, "R6 held level does not reset");
        thermtrip = 1'b0; cyc(1);
        thermtrip = 1'b1; cyc(1); thermtrip = 1'b0;
        expect_rd(8'hA8, "R6 second edge");
        warm_pulse();
        expect_rd(8'hA0, "R6 warm clears bit3");

        // resume-well reset, then power-up start with strobe already low
        rst = 1'b1; cyc(2);
        expect_rd(8'h00, "R2 R3 resume reset clears");
        slp_strobe = 1'b0;
        rst = 1'b0; cyc(1);
        expect_rd(8'h04, "R7 power-up start short");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule